// File: doc/BRIEF.md
# Infrared Run-Length Sampler

This block watches the single-bit output of an infrared receiver and turns it into a stream of byte entries for a receive FIFO. A free-running divider makes one sample tick every `DIV` clocks. On each tick the input is sampled, optionally inverted, and passed through a glitch filter. Every stable stretch of the filtered line becomes one entry: bit 7 is the level (1 = pulse, 0 = space) and bits 6:0 are the run length in ticks minus one. A run that outlasts one entry is split into several entries of the same level.

A packet ends when the line has been at the space level for a programmable time. The block then gives a one-cycle end strobe, drops the space it was counting, and waits for the next pulse before it emits anything again. Both thresholds come from one 16-bit configuration word. The noise threshold sits in bits 7:2 and the idle threshold in bits 15:8. Bits 1:0 are ignored.

Top module: `ir_run_sampler`

## Requirements
- R1: One sample is taken every `DIV` (default 64) clocks while the block is active, and every run length is counted in these samples.
- R2: The block is active only when `glb_en` and `rx_en` are both 1 and `mode` equals 2'b11. While inactive it pushes nothing, raises no end strobe, and discards any run in progress. After it becomes active again it starts from the waiting state.
- R3: An entry is 8 bits: bit 7 is 1 for a pulse and 0 for a space, and bits 6:0 hold the run length in ticks minus one.
- R4: A run longer than 128 ticks is pushed as 0x7F/0xFF entries of 128 ticks each, followed by one entry for the remainder. A run of exactly 128 ticks gives a single entry.
- R5: With `invert` = 1 the sampled input is complemented, so a low receiver output counts as a pulse.
- R6: A level change held for no more than N ticks is absorbed into the surrounding run, where N = `cfg[7:2]`. A change held for N+1 ticks or more is accepted, and the lengths of both runs are preserved.
- R7: When a space within a packet reaches (M+1)*128 ticks, where M = `cfg[15:8]`, `pkt_end` is high for one clock. In that clock there is no push. The M full 128-tick space entries already pushed remain, and the partial space is dropped.
- R8: Spaces seen before the first pulse, whether after enable or after a packet end, are never pushed. The first entry after either event is a pulse entry.
- R9: `push` is a one-clock strobe, and at most one entry is pushed per tick.
- R10: While reset is asserted and right after it is released, `push` and `pkt_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Raw receiver output (asynchronous) |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | Operating mode; 2'b11 selects IR receive |
| invert | input | 1 | Complement the input before sampling |
| cfg | input | 16 | Sample configuration: noise threshold [7:2], idle threshold [15:8] |
| push | output | 1 | One-clock strobe: write `push_data` into the FIFO |
| push_data | output | 8 | Run entry {level, length-1} |
| pkt_end | output | 1 | One-clock packet-end strobe |

## Verification
Two functions can fall on the same tick: closing a full 128-tick entry and closing a run on a level change. The bench provokes this with a pulse of exactly 128 ticks followed by a space, and expects a single 0xFF entry followed by the space entry, with no empty or duplicate entry between them. A second case puts a 200-tick space inside a packet whose idle limit is 256 ticks. There the bench checks that the split space entry is pushed and that the packet does not end too early.

// File: rtl/ir_run_sampler.sv
module ir_run_sampler #(
  parameter int DIV   = 64,
  parameter int LEN_W = 7,
  parameter int NTH_W = 6,
  parameter int ITH_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  input  logic             glb_en,
  input  logic             rx_en,
  input  logic [1:0]       mode,
  input  logic             invert,
  input  logic [ITH_W+7:0] cfg,
  output logic             push,
  output logic [LEN_W:0]   push_data,
  output logic             pkt_end
);
  localparam int PRE_W = $clog2(DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);
  localparam logic [LEN_W-1:0] LEN_MAX  = '1;
  localparam logic [LEN_W-1:0] LEN_PEN  = LEN_MAX - 1'b1;
  localparam logic [1:0]       MODE_IR  = 2'b11;

  logic [1:0]       sync_q;
  logic [PRE_W-1:0] pre_q;
  logic             filt_q, filt_n;
  logic [NTH_W-1:0] gl_q, gl_n;
  logic             busy_q, busy_n;
  logic             lvl_q, lvl_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [ITH_W:0]   chunks_q, chunks_n;
  logic             emit, end_ev;
  logic [LEN_W:0]   edat;

  wire              act  = glb_en && rx_en && (mode == MODE_IR);
  wire              tick = act && (pre_q == PRE_LAST);
  wire              samp = sync_q[1] ^ invert;
  wire [NTH_W-1:0]  nthr = cfg[2 +: NTH_W];
  wire [ITH_W-1:0]  ithr = cfg[8 +: ITH_W];
  logic             cfg_unused;
  assign cfg_unused = ^cfg[1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ir_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         pre_q <= '0;
    else if (!act)      pre_q <= '0;
    else if (tick)      pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;

  always_comb begin
    filt_n = filt_q;
    gl_n   = '0;
    if (samp != filt_q) begin
      if (gl_q == nthr) filt_n = samp;
      else              gl_n   = gl_q + 1'b1;
    end
  end

  always_comb begin
    emit     = 1'b0;
    end_ev   = 1'b0;
    edat     = {lvl_q, len_q};
    busy_n   = busy_q;
    lvl_n    = lvl_q;
    len_n    = len_q;
    chunks_n = chunks_q;
    if (!busy_q) begin
      if (filt_n) begin
        busy_n   = 1'b1;
        lvl_n    = 1'b1;
        len_n    = '0;
        chunks_n = '0;
      end
    end else if (filt_n != lvl_q) begin
      emit     = 1'b1;
      lvl_n    = filt_n;
      len_n    = '0;
      chunks_n = '0;
    end else if (!lvl_q && len_q == LEN_PEN && chunks_q == {1'b0, ithr}) begin
      end_ev = 1'b1;
      busy_n = 1'b0;
    end else if (len_q == LEN_MAX) begin
      emit     = 1'b1;
      len_n    = '0;
      chunks_n = chunks_q + 1'b1;
    end else begin
      len_n = len_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      filt_q   <= 1'b0;
      gl_q     <= '0;
      busy_q   <= 1'b0;
      lvl_q    <= 1'b0;
      len_q    <= '0;
      chunks_q <= '0;
    end else if (!act) begin
      filt_q   <= 1'b0;
      gl_q     <= '0;
      busy_q   <= 1'b0;
      lvl_q    <= 1'b0;
      len_q    <= '0;
      chunks_q <= '0;
    end else if (tick) begin
      filt_q   <= filt_n;
      gl_q     <= gl_n;
      busy_q   <= busy_n;
      lvl_q    <= lvl_n;
      len_q    <= len_n;
      chunks_q <= chunks_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      push      <= 1'b0;
      pkt_end   <= 1'b0;
      push_data <= '0;
    end else begin
      push    <= tick && emit;
      pkt_end <= tick && end_ev;
      if (tick && emit) push_data <= edat;
    end
endmodule

module ir_run_sampler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_en,
  input logic       rx_en,
  input logic [1:0] mode,
  input logic       push,
  input logic       ent_lvl,
  input logic       pkt_end
);
  wire act = glb_en && rx_en && (mode == 2'b11);
  logic fresh_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               fresh_q <= 1'b1;
    else if (!act || pkt_end) fresh_q <= 1'b1;
    else if (push)            fresh_q <= 1'b0;

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (!push && !pkt_end));
  assert_no_push_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pkt_end));
  assert_end_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end);
  assert_push_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);
  assert_first_is_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fresh_q) |-> ent_lvl);
endmodule

bind ir_run_sampler ir_run_sampler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rx_en(rx_en), .mode(mode),
  .push(push), .ent_lvl(push_data[7]), .pkt_end(pkt_end)
);

// File: tb/sim_ir_run_sampler.sv
module sim_ir_run_sampler;
  logic clk = 1'b0, rst_n = 1'b0, ir_in = 1'b0, glb_en = 1'b0, rx_en = 1'b0, invert = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic [15:0] cfg = 16'h0003;
  logic        push, pkt_end;
  logic [7:0]  push_data;

  int checks = 0, errors = 0;
  int ncap = 0, npe = 0;
  logic [7:0] cap [0:63];

  always #5 clk = ~clk;

  ir_run_sampler u0 (.clk(clk), .rst_n(rst_n), .ir_in(ir_in), .glb_en(glb_en), .rx_en(rx_en),
    .mode(mode), .invert(invert), .cfg(cfg), .push(push), .push_data(push_data), .pkt_end(pkt_end));

  always @(negedge clk) begin
    if (push) begin
      if (ncap < 64) cap[ncap] = push_data;
      ncap = ncap + 1;
    end
    if (pkt_end) npe = npe + 1;
  end

  typedef struct packed {
    logic            inv;
    logic [5:0]      nth;
    logic [7:0]      ith;
    logic [2:0]      nseg;
    logic [3:0][10:0] seg;
    logic [2:0]      nexp;
    logic [5:0][7:0] ex;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{1'b0, 6'd0, 8'd0, 3'd3, {11'h000, 11'h405, 11'h014, 11'h40A}, 3'd3, {8'h00, 8'h00, 8'h00, 8'h84, 8'h13, 8'h89}},
    '{1'b0, 6'd0, 8'd0, 3'd1, {11'h000, 11'h000, 11'h000, 11'h52C}, 3'd3, {8'h00, 8'h00, 8'h00, 8'hAB, 8'hFF, 8'hFF}},
    '{1'b0, 6'd2, 8'd0, 3'd3, {11'h000, 11'h40A, 11'h002, 11'h40A}, 3'd1, {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h95}},
    '{1'b0, 6'd2, 8'd0, 3'd3, {11'h000, 11'h40A, 11'h003, 11'h40A}, 3'd3, {8'h00, 8'h00, 8'h00, 8'h89, 8'h02, 8'h89}},
    '{1'b1, 6'd0, 8'd0, 3'd3, {11'h000, 11'h405, 11'h014, 11'h40A}, 3'd3, {8'h00, 8'h00, 8'h00, 8'h84, 8'h13, 8'h89}},
    '{1'b0, 6'd0, 8'd1, 3'd3, {11'h000, 11'h405, 11'h0C8, 11'h405}, 3'd5, {8'h00, 8'h7F, 8'h84, 8'h47, 8'h7F, 8'h84}},
    '{1'b0, 6'd0, 8'd0, 3'd3, {11'h000, 11'h401, 11'h005, 11'h480}, 3'd3, {8'h00, 8'h00, 8'h00, 8'h80, 8'h04, 8'hFF}}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input logic lvl, input int n);
    ir_in = lvl;
    repeat (n * 64) @(negedge clk);
  endtask

  task automatic restart(input logic inv, input logic [15:0] c);
    @(negedge clk);
    glb_en = 1'b0;
    invert = inv;
    cfg    = c;
    ir_in  = inv;
    repeat (4) @(negedge clk);
    glb_en = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0, p0;
    rx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!push && !pkt_end, "R10 outputs in reset", {push, pkt_end}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!push && !pkt_end, "R10 outputs after reset", {push, pkt_end}, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VT[v];
      restart(t.inv, {t.ith, t.nth, 2'b11});
      c0 = ncap; p0 = npe;
      ticks(t.inv, 5);
      for (int s = 0; s < int'(t.nseg); s++)
        ticks(t.seg[s][10] ^ t.inv, int'(t.seg[s][9:0]));
      ticks(t.inv, (int'(t.ith) + 1) * 128 + int'(t.nth) + 8);
      chk(ncap - c0 == int'(t.nexp), $sformatf("R3 R4 R6 entry count vec %0d", v), ncap - c0, t.nexp);
      chk(npe - p0 == 1, $sformatf("R7 packet end vec %0d", v), npe - p0, 1);
      for (int k = 0; k < int'(t.nexp); k++)
        if (c0 + k < ncap)
          chk(cap[c0 + k] == t.ex[k], $sformatf("R1 R3 R4 R5 R6 R7 entry %0d vec %0d", k, v), cap[c0 + k], t.ex[k]);
    end

    // R8: a new pulse after packet end restarts without re-enable
    c0 = ncap; p0 = npe;
    ticks(1'b1, 4);
    ticks(1'b0, 136);
    chk(ncap - c0 == 1, "R8 restart entry count", ncap - c0, 1);
    chk(c0 < ncap && cap[c0] == 8'h83, "R8 restart entry", (c0 < ncap) ? cap[c0] : 0, 8'h83);
    chk(npe - p0 == 1, "R8 restart packet end", npe - p0, 1);

    // R2: wrong mode
    restart(1'b0, 16'h0003);
    mode = 2'b01;
    c0 = ncap; p0 = npe;
    ticks(1'b1, 5);
    ticks(1'b0, 136);
    chk(ncap == c0 && npe == p0, "R2 wrong mode silent", ncap - c0 + npe - p0, 0);
    mode = 2'b11;

    // R2: global enable off
    glb_en = 1'b0;
    ticks(1'b1, 5);
    ticks(1'b0, 20);
    chk(ncap == c0 && npe == p0, "R2 global enable off silent", ncap - c0 + npe - p0, 0);

    // R2: disable mid-run discards the run in progress
    restart(1'b0, 16'h0003);
    c0 = ncap; p0 = npe;
    ticks(1'b0, 3);
    ticks(1'b1, 5);
    glb_en = 1'b0;
    ir_in  = 1'b0;
    repeat (10) @(negedge clk);
    glb_en = 1'b1;
    ticks(1'b0, 3);
    ticks(1'b1, 3);
    ticks(1'b0, 136);
    chk(ncap - c0 == 1, "R2 mid-run disable count", ncap - c0, 1);
    chk(c0 < ncap && cap[c0] == 8'h82, "R2 mid-run disable entry", (c0 < ncap) ? cap[c0] : 0, 8'h82);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule